// File: doc/BRIEF.md
# Dual-Bank Programmable Clock Divider

This block takes two reference clocks and passes one of them, picked by a select input, to two output banks. Each bank has its own 3-bit ratio code and divides the chosen clock by 1, 2, 3, 4, 5, 6, 8 or 16. The output keeps a 50% duty cycle at every ratio. For the odd ratios 3 and 5 this needs a flop on the falling edge as well as the rising one. Each bank drives a group of identical clock outputs from one divider. Each bank also has its own enable, which drives a pad output-enable for the high-impedance pad buffer and holds the bank's data bits low while the enable is low.

The block is reset synchronously. Reset puts both banks into a common phase, so the first rising edge after reset starts a high phase on every output. A new ratio code is sampled only on the rising edge that ends the current output period, so the output never shows a shortened pulse. When the ratio inputs are left at zero, the bank passes the selected clock through at divide-by-one.

Top module: `dcd_fanout`

## Requirements
- R1: The ratio code of a bank sets the division N as follows: 3'b000=1, 3'b001=2, 3'b010=3, 3'b011=4, 3'b100=5, 3'b101=6, 3'b110=8, 3'b111=16. The output period equals N periods of the selected clock.
- R2: Count the half-periods of the selected clock from the rising edge that opens an output period. The output is high in half-periods 0 to N-1 and low in half-periods N to 2N-1. This gives exactly 50% duty for odd N too. At N=1 the output follows the selected clock.
- R3: With `ref_sel` low the banks divide `ref_clk0`. With `ref_sel` high they divide `ref_clk1`.
- R4: While `rst` is high, all clock outputs are low. The first rising edge of the selected clock that samples `rst` low opens a new output period in both banks at the same time.
- R5: A bank samples its ratio code only on the rising edge that closes its current output period. A code change made in the middle of a period takes effect only in the following period.
- R6: While a bank enable is low, that bank's pad output-enable is low and all its data bits are low. While the enable is high, the pad output-enable is high. The divider keeps counting while the bank is disabled, so the output comes back in its normal phase.
- R7: All outputs of one bank carry the same value at all times.
- R8: The two banks divide independently. Changing one bank's ratio code or enable does not change the other bank's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk0 | input | 1 | Reference clock chosen when `ref_sel` is low |
| ref_clk1 | input | 1 | Reference clock chosen when `ref_sel` is high |
| ref_sel | input | 1 | Reference select |
| rst | input | 1 | Synchronous active-high reset, sampled on the selected clock |
| ratio_a | input | 3 | Ratio code of bank A |
| ratio_b | input | 3 | Ratio code of bank B |
| drive_en_a | input | 1 | Output enable of bank A |
| drive_en_b | input | 1 | Output enable of bank B |
| clk_out_a | output | OUTS_PER_BANK | Bank A clock outputs |
| clk_out_b | output | OUTS_PER_BANK | Bank B clock outputs |
| pad_oe_a | output | 1 | Pad output-enable for bank A (high = drive, low = high impedance) |
| pad_oe_b | output | 1 | Pad output-enable for bank B (high = drive, low = high impedance) |

## Verification
The checker builds its own sampling clock from `ref_sel` and the two references. Its properties therefore assume that the select changes only while reset is held, when a clock glitch from the switch cannot matter. The stimulus follows this rule: it switches `ref_sel` only inside a reset window, and it changes ratio codes and enables half a cycle away from the rising edge. The random phases vary codes and enables freely under these timing rules. Directed phases sweep all eight codes from reset, change a code in the middle of a period, and run the second reference.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  localparam int CODE_W    = 3;
  localparam int MAX_RATIO = 16;
  localparam int PHASE_W   = $clog2(MAX_RATIO);

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [PHASE_W-1:0] phase_t;

  // Division selected by a ratio code (non-linear at the top end).
  function automatic int ratio_of(input code_t code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      3'd4:    return 5;
      3'd5:    return 6;
      3'd6:    return 8;
      default: return 16;
    endcase
  endfunction

  // Phase index of the last rising edge inside an output period.
  function automatic phase_t last_phase(input code_t code);
    return phase_t'(ratio_of(code) - 1);
  endfunction

  function automatic logic is_odd_ratio(input code_t code);
    return (ratio_of(code) % 2) == 1 && ratio_of(code) > 1;
  endfunction

endpackage

// File: rtl/dcd_clk_mux.sv
module dcd_clk_mux (
  input  logic ref_clk0,
  input  logic ref_clk1,
  input  logic ref_sel,
  output logic clk_sel
);
  // Select is expected to move only while the dividers are held in reset.
  assign clk_sel = ref_sel ? ref_clk1 : ref_clk0;
endmodule

// File: rtl/dcd_divider.sv
module dcd_divider
  import dcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  code_t code,
  output logic  div_o
);

  code_t  act_code;
  phase_t phase;
  logic   rise_lvl;
  logic   fall_lvl;
  logic   running;
  logic   wrap;
  logic   pass_thru;
  int     act_ratio;
  int     next_phase;

  assign act_ratio  = ratio_of(act_code);
  assign wrap       = (phase == last_phase(act_code));
  assign next_phase = int'(phase) + 1;
  assign pass_thru  = (act_ratio == 1);

  // Rising-edge half: phase counter and the level for the first half-period.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_code <= code;
      phase    <= last_phase(code);
      rise_lvl <= 1'b0;
      running  <= 1'b0;
    end else begin
      running <= 1'b1;
      if (wrap) begin
        act_code <= code;
        phase    <= '0;
        rise_lvl <= (1 < ratio_of(code));
      end else begin
        phase    <= phase_t'(next_phase);
        rise_lvl <= ((2 * next_phase + 1) < act_ratio);
      end
    end
  end

  // Falling-edge copy stretches odd ratios by one half-period.
  always_ff @(negedge clk) begin
    if (rst) begin
      fall_lvl <= 1'b0;
    end else begin
      fall_lvl <= rise_lvl & is_odd_ratio(act_code);
    end
  end

  assign div_o = running & (pass_thru ? clk : (rise_lvl | fall_lvl));

endmodule

// File: rtl/dcd_out_stage.sv
module dcd_out_stage #(
  parameter int WIDTH = 2
) (
  input  logic             enable,
  input  logic             level,
  output logic [WIDTH-1:0] q,
  output logic             pad_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign q[i] = enable & level;
  end
  assign pad_oe = enable;
endmodule

// File: rtl/dcd_fanout.sv
module dcd_fanout
  import dcd_pkg::*;
#(
  parameter int OUTS_PER_BANK = 2
) (
  input  logic                     ref_clk0,
  input  logic                     ref_clk1,
  input  logic                     ref_sel,
  input  logic                     rst,
  input  logic [CODE_W-1:0]        ratio_a,
  input  logic [CODE_W-1:0]        ratio_b,
  input  logic                     drive_en_a,
  input  logic                     drive_en_b,
  output logic [OUTS_PER_BANK-1:0] clk_out_a,
  output logic [OUTS_PER_BANK-1:0] clk_out_b,
  output logic                     pad_oe_a,
  output logic                     pad_oe_b
);

  localparam int NUM_BANKS = 2;

  logic clk_sel;

  code_t                                    bank_code [NUM_BANKS];
  logic [NUM_BANKS-1:0]                     bank_en;
  logic [NUM_BANKS-1:0]                     bank_lvl;
  logic [NUM_BANKS-1:0]                     bank_oe;
  logic [NUM_BANKS-1:0][OUTS_PER_BANK-1:0]  bank_q;

  dcd_clk_mux u_mux (
    .ref_clk0 (ref_clk0),
    .ref_clk1 (ref_clk1),
    .ref_sel  (ref_sel),
    .clk_sel  (clk_sel)
  );

  assign bank_code[0] = ratio_a;
  assign bank_code[1] = ratio_b;
  assign bank_en      = {drive_en_b, drive_en_a};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dcd_divider u_div (
      .clk   (clk_sel),
      .rst   (rst),
      .code  (bank_code[b]),
      .div_o (bank_lvl[b])
    );

    dcd_out_stage #(.WIDTH(OUTS_PER_BANK)) u_out (
      .enable (bank_en[b]),
      .level  (bank_lvl[b]),
      .q      (bank_q[b]),
      .pad_oe (bank_oe[b])
    );
  end

  assign clk_out_a = bank_q[0];
  assign clk_out_b = bank_q[1];
  assign pad_oe_a  = bank_oe[0];
  assign pad_oe_b  = bank_oe[1];

endmodule

// File: rtl/dcd_fanout_chk.sv
module dcd_fanout_chk #(
  parameter int OUTS_PER_BANK = 2
) (
  input logic                     ref_clk0,
  input logic                     ref_clk1,
  input logic                     ref_sel,
  input logic                     rst,
  input logic                     drive_en_a,
  input logic                     drive_en_b,
  input logic [OUTS_PER_BANK-1:0] clk_out_a,
  input logic [OUTS_PER_BANK-1:0] clk_out_b,
  input logic                     pad_oe_a,
  input logic                     pad_oe_b
);
  logic chk_ck;
  assign chk_ck = ref_sel ? ref_clk1 : ref_clk0;

  // R6
  bank_a_quiet_chk: assert property (@(posedge chk_ck) disable iff (rst)
    !drive_en_a |-> (clk_out_a == '0 && !pad_oe_a));

  // R6
  bank_b_quiet_chk: assert property (@(posedge chk_ck) disable iff (rst)
    !drive_en_b |-> (clk_out_b == '0 && !pad_oe_b));

  // R6
  pads_driven_chk: assert property (@(posedge chk_ck) disable iff (rst)
    (drive_en_a |-> pad_oe_a) and (drive_en_b |-> pad_oe_b));

  // R7
  bank_pair_match_chk: assert property (@(posedge chk_ck) disable iff (rst)
    clk_out_a == {OUTS_PER_BANK{clk_out_a[0]}} &&
    clk_out_b == {OUTS_PER_BANK{clk_out_b[0]}});

  // R4
  low_out_of_reset_chk: assert property (@(posedge chk_ck) disable iff (rst)
    $fell(rst) |-> (clk_out_a == '0 && clk_out_b == '0));
endmodule

bind dcd_fanout dcd_fanout_chk #(.OUTS_PER_BANK(OUTS_PER_BANK)) u_chk (
  .ref_clk0   (ref_clk0),
  .ref_clk1   (ref_clk1),
  .ref_sel    (ref_sel),
  .rst        (rst),
  .drive_en_a (drive_en_a),
  .drive_en_b (drive_en_b),
  .clk_out_a  (clk_out_a),
  .clk_out_b  (clk_out_b),
  .pad_oe_a   (pad_oe_a),
  .pad_oe_b   (pad_oe_b)
);

// File: tb/dcd_fanout_test.sv
module dcd_fanout_test;
  localparam int OUTS = 2;

  logic ref0 = 1'b0;
  logic ref1 = 1'b0;
  logic sel  = 1'b0;
  logic rst  = 1'b1;
  logic [2:0] ca = 3'd0;
  logic [2:0] cb = 3'd0;
  logic ena = 1'b1;
  logic enb = 1'b1;
  logic [OUTS-1:0] qa, qb;
  logic oea, oeb;
  logic sck;

  int checks = 0;
  int fails  = 0;

  // Reference model state.
  bit in_rst = 1'b1;
  int na = 1, pa = 0, nb = 1, pb = 0;

  always #4 ref0 = ~ref0;
  always #6 ref1 = ~ref1;
  assign sck = sel ? ref1 : ref0;

  dcd_fanout #(.OUTS_PER_BANK(OUTS)) uut (
    .ref_clk0(ref0), .ref_clk1(ref1), .ref_sel(sel), .rst(rst),
    .ratio_a(ca), .ratio_b(cb), .drive_en_a(ena), .drive_en_b(enb),
    .clk_out_a(qa), .clk_out_b(qb), .pad_oe_a(oea), .pad_oe_b(oeb)
  );

  function automatic int ratio_f(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
      3'd4: return 5;  3'd5: return 6;  3'd6: return 8;  default: return 16;
    endcase
  endfunction

  function automatic logic lvl(input int n, input int p, input int h);
    return (2 * p + h) < n;
  endfunction

  task automatic check_vec(input string tag, input logic [OUTS-1:0] act,
                           input logic [OUTS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_rise();
    if (in_rst) return;
    if (pa == na - 1) begin pa = 0; na = ratio_f(ca); end else pa++;
    if (pb == nb - 1) begin pb = 0; nb = ratio_f(cb); end else pb++;
  endtask

  task automatic check_half(input int h, input string tag_a, input string tag_b);
    logic ea, eb;
    ea = !in_rst && ena && lvl(na, pa, h);
    eb = !in_rst && enb && lvl(nb, pb, h);
    check_vec(in_rst ? "R4 bank A" : tag_a, qa, {OUTS{ea}});
    check_vec(in_rst ? "R4 bank B" : tag_b, qb, {OUTS{eb}});
    check_vec("R6 pad enables", {{(OUTS-2){1'b0}}, oeb, oea}, {{(OUTS-2){1'b0}}, enb, ena});
    check_vec("R7 bank A pair", qa, {OUTS{qa[0]}});
  endtask

  // mode 0: fixed inputs, 1: fully random, 2: only bank B random
  task automatic run_cycles(input int n, input int mode,
                            input string tag_a, input string tag_b);
    for (int i = 0; i < n; i++) begin
      @(posedge sck); #1;
      model_rise();
      check_half(0, tag_a, tag_b);
      @(negedge sck); #1;
      check_half(1, tag_a, tag_b);
      if (mode == 1) begin
        if ($urandom_range(0, 7) == 0) ca = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 7) == 0) cb = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 9) == 0) ena = ~ena;
        if ($urandom_range(0, 9) == 0) enb = ~enb;
      end else if (mode == 2) begin
        if ($urandom_range(0, 3) == 0) cb = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 5) == 0) enb = ~enb;
      end
    end
  endtask

  task automatic do_reset(input logic s, input logic [2:0] a, input logic [2:0] b);
    @(negedge sck); #1;
    rst = 1'b1; in_rst = 1'b1;
    run_cycles(2, 0, "R4", "R4");
    sel = s; ca = a; cb = b; ena = 1'b1; enb = 1'b1;
    run_cycles(3, 0, "R4", "R4");
    rst = 1'b0; in_rst = 1'b0;
    na = 1; pa = 0; nb = 1; pb = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    // Reset state checked inside do_reset (R4).
    run_cycles(3, 0, "R4", "R4");

    // R1 R2: every code on bank A, mirrored code on bank B.
    for (int c = 0; c < 8; c++) begin
      do_reset(1'b0, 3'(c), 3'(7 - c));
      run_cycles(40, 0, "R1 R2 bank A", "R1 R2 bank B");
    end

    // R5: change the code in the middle of a period.
    do_reset(1'b0, 3'd4, 3'd2);
    run_cycles(2, 0, "R5 bank A", "R5 bank B");
    ca = 3'd7; cb = 3'd0;
    run_cycles(10, 0, "R5 bank A", "R5 bank B");
    ca = 3'd2; cb = 3'd6;
    run_cycles(30, 0, "R5 bank A", "R5 bank B");

    // R8: bank A held at divide-by-5 while bank B is varied.
    do_reset(1'b0, 3'd4, 3'd1);
    run_cycles(200, 2, "R8 bank A", "R2 bank B");

    // R6: disable both banks, then bring them back in phase.
    ena = 1'b0; enb = 1'b0;
    run_cycles(12, 0, "R6 bank A", "R6 bank B");
    ena = 1'b1; enb = 1'b1;
    run_cycles(12, 0, "R6 bank A", "R6 bank B");

    // R3: second reference clock.
    do_reset(1'b1, 3'd2, 3'd5);
    run_cycles(60, 0, "R3 bank A", "R3 bank B");
    run_cycles(300, 1, "R3 R2 bank A", "R3 R2 bank B");

    // R2: random stress on the first reference.
    do_reset(1'b0, 3'd6, 3'd3);
    run_cycles(500, 1, "R2 bank A", "R2 bank B");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule